// File: doc/BRIEF.md
# Gapped Nibble-Strobe Payload Input for a DS3 Transmit Framer

This block sits at the transmit payload input of a DS3 framer running with a 4-bit parallel payload path, a local bit-rate clock and frame timing taken from the terminal equipment. It runs on the bit clock (44.736 MHz in a real DS3 line, giving a nominal nibble rate of 11.184 MHz). It divides that clock into nibble slots. Most slots last four bit periods. Fourteen slots in every frame last five, which leaves room for the overhead bits that the framer inserts itself. A one-cycle strobe marks the last bit period of each slot. On that clock edge the block samples the 4-bit payload bus and passes the nibble downstream with its slot index and a marker for the first nibble of the frame.

The terminal equipment sends a one-period frame-reference pulse with the first nibble of each frame. A rising edge on that input discards whatever frame is in progress and restarts the sequence at slot 0. Until the first such edge after reset, the block free-runs its slot sequence and reports that it is not yet aligned. In this mode the framer generates all overhead internally, so the overhead-indicator output is always held low.

Top module: `nibgap_tx_in`

## Requirements
- R1: After a synchronous active-high reset, the capture-valid output is 0, the strobe output is 0, the not-aligned flag is 1, and the slot sequence starts at slot 0, bit period 0.
- R2: A slot that is not stretched lasts 4 bit-clock periods, and the strobe is high only in its 4th period. Slots advance by one and wrap from SLOTS-1 to 0.
- R3: Each frame has SLOTS slots, and exactly 14 of them last 5 periods, with the strobe in the 5th. With L = SLOTS/7, slot s is stretched when s mod L equals 0 or L/2. A frame therefore lasts 4*SLOTS+14 bit periods (182 periods for SLOTS=42).
- R4: When the frame-reference input is sampled high at a clock edge after being sampled low at the previous edge (a rising edge), the next cycle is bit period 0 of slot 0. If the reference then stays high, no further restart occurs.
- R5: At every clock edge where the strobe is high and no restart is taken, the payload bus is captured. In the next cycle the valid output is high for exactly one cycle and carries the nibble, the slot index of the strobe, and a first-of-frame bit that is 1 only for slot 0.
- R6: The overhead-indicator output is 0 in every cycle.
- R7: The not-aligned flag stays 1 from reset until the first rising edge of the reference and is 0 in the cycle after it. It stays 0 until the next reset.
- R8: If a rising edge of the reference coincides with a strobe, no nibble is captured: valid is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| pay_nib_i | input | 4 | Payload nibble from the terminal equipment |
| frame_ref_i | input | 1 | Start-of-frame reference from the terminal equipment |
| nib_stb_o | output | 1 | Nibble strobe, high in the last bit period of each slot |
| ovh_ind_o | output | 1 | Overhead indicator, always low |
| cap_valid_o | output | 1 | One-cycle pulse marking a captured nibble |
| cap_nib_o | output | 4 | Captured nibble |
| cap_slot_o | output | $clog2(SLOTS) | Slot index of the captured nibble |
| cap_first_o | output | 1 | Captured nibble is slot 0 of the frame |
| unaligned_o | output | 1 | No reference edge seen since reset |

## Verification
The hardest case to reach from the ports is a reference edge that arrives at every possible bit offset inside a frame. That includes offsets that coincide with a strobe, offsets inside a five-period slot, and offsets in the last slot just before wrap. The bench sweeps the delay between successive reference pulses across a whole frame length in a small configuration (42 slots). A cycle-accurate model in the bench, built from the requirements, predicts every strobe, capture and flag. Held-high references, mid-run resets and a frame-length measurement cover the remaining cases.

// File: rtl/nibgap_pkg.sv
package nibgap_pkg;

    localparam int unsigned NIB_W       = 4;
    localparam int unsigned SHORT_LEN   = 4;
    localparam int unsigned LONG_LEN    = 5;
    localparam int unsigned SUBFRAMES   = 7;
    localparam int unsigned BCNT_W      = 3;

    typedef struct packed {
        logic             valid;
        logic             first;
        logic [NIB_W-1:0] nib;
    } cap_word_t;

    // A slot is stretched at the start and the middle of every subframe.
    function automatic logic is_long_slot(input int unsigned slot,
                                          input int unsigned slots);
        int unsigned sub_len;
        int unsigned off;
        sub_len = slots / SUBFRAMES;
        off     = slot % sub_len;
        return (off == 0) || (off == sub_len / 2);
    endfunction

endpackage

// File: rtl/nibgap_ref_edge.sv
module nibgap_ref_edge (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    output logic restart,
    output logic unaligned
);
    logic ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q     <= 1'b0;
            unaligned <= 1'b1;
        end else begin
            ref_q <= ref_i;
            if (restart) unaligned <= 1'b0;
        end
    end

    assign restart = ref_i & ~ref_q;

    // R7: once aligned, stays aligned until reset
    p_align_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !unaligned |=> !unaligned);
    // R7: a restart always clears the flag
    p_align_clear_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !unaligned);
    // R4: a held reference does not restart twice in a row
    p_single_restart_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);
endmodule

// File: rtl/nibgap_slot_timer.sv
module nibgap_slot_timer
    import nibgap_pkg::*;
#(
    parameter int unsigned SLOTS = 1176,
    localparam int unsigned SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic          stb,
    output logic [SW-1:0] slot
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    logic [BCNT_W-1:0] bcnt;
    logic [BCNT_W-1:0] last_bit;
    logic              long_slot;

    always_comb begin
        long_slot = is_long_slot(32'(slot), SLOTS);
        last_bit  = long_slot ? BCNT_W'(LONG_LEN - 1) : BCNT_W'(SHORT_LEN - 1);
        stb       = (bcnt == last_bit);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            bcnt <= '0;
            slot <= '0;
        end else if (stb) begin
            bcnt <= '0;
            slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end else begin
            bcnt <= bcnt + 1'b1;
        end
    end

    // R4: a restart lands on bit 0 of slot 0
    p_restart_origin_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (slot == '0) && (bcnt == '0) && !stb);
    // R3: the last slot wraps to slot 0
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (stb && !restart && slot == LAST_SLOT) |=> slot == '0);
    // R2: slots advance by one
    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (stb && !restart && slot != LAST_SLOT) |=> slot == $past(slot) + 1'b1);
    // R2: slot index holds between strobes
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!stb && !restart) |=> $stable(slot));
endmodule

// File: rtl/nibgap_capture.sv
module nibgap_capture
    import nibgap_pkg::*;
#(
    parameter int unsigned SW = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             restart,
    input  logic [NIB_W-1:0] nib_i,
    input  logic [SW-1:0]    slot_i,
    output cap_word_t        word_o,
    output logic [SW-1:0]    slot_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            slot_o <= '0;
        end else begin
            word_o.valid <= stb & ~restart;
            if (stb && !restart) begin
                word_o.nib   <= nib_i;
                word_o.first <= (slot_i == '0);
                slot_o       <= slot_i;
            end
        end
    end

    // R5: every accepted strobe yields a capture tagged with its slot
    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (stb && !restart) |=> word_o.valid && (slot_o == $past(slot_i)));
    // R8: no capture when a restart is taken
    p_no_capture_r8: assert property (@(posedge clk) disable iff (rst)
        restart |=> !word_o.valid);
    // R5: captured data is the bus value at the strobe edge
    p_data_r5: assert property (@(posedge clk) disable iff (rst)
        (stb && !restart) |=> word_o.nib == $past(nib_i));
endmodule

// File: rtl/nibgap_tx_in.sv
module nibgap_tx_in
    import nibgap_pkg::*;
#(
    parameter int unsigned SLOTS = 1176,
    localparam int unsigned SW   = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] pay_nib_i,
    input  logic             frame_ref_i,
    output logic             nib_stb_o,
    output logic             ovh_ind_o,
    output logic             cap_valid_o,
    output logic [NIB_W-1:0] cap_nib_o,
    output logic [SW-1:0]    cap_slot_o,
    output logic             cap_first_o,
    output logic             unaligned_o
);
    logic          restart;
    logic [SW-1:0] slot;
    cap_word_t     word;

    nibgap_ref_edge u_ref (
        .clk       (clk),
        .rst       (rst),
        .ref_i     (frame_ref_i),
        .restart   (restart),
        .unaligned (unaligned_o)
    );

    nibgap_slot_timer #(.SLOTS(SLOTS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .stb     (nib_stb_o),
        .slot    (slot)
    );

    nibgap_capture #(.SW(SW)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .stb     (nib_stb_o),
        .restart (restart),
        .nib_i   (pay_nib_i),
        .slot_i  (slot),
        .word_o  (word),
        .slot_o  (cap_slot_o)
    );

    assign cap_valid_o = word.valid;
    assign cap_nib_o   = word.nib;
    assign cap_first_o = word.first;
    // R6: overhead is produced internally in this mode
    assign ovh_ind_o   = 1'b0;

    // R5: capture valid is a single-cycle pulse (slots are at least 4 long)
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        cap_valid_o |=> !cap_valid_o);
endmodule

// File: tb/nibgap_tx_in_test.sv
module nibgap_tx_in_test;
    localparam int SLOTS = 42;
    localparam int SW    = $clog2(SLOTS);
    localparam int SUBL  = SLOTS / 7;
    localparam int FRAME = 4 * SLOTS + 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    pay_nib = '0;
    logic          frame_ref = 1'b0;
    logic          nib_stb, ovh_ind, cap_valid, cap_first, unaligned;
    logic [3:0]    cap_nib;
    logic [SW-1:0] cap_slot;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    int ms, mb, pv, pnib, pslot, pfirst, mun, prev_r;

    always #2 clk = ~clk;

    nibgap_tx_in #(.SLOTS(SLOTS)) uut (
        .clk(clk), .rst(rst), .pay_nib_i(pay_nib), .frame_ref_i(frame_ref),
        .nib_stb_o(nib_stb), .ovh_ind_o(ovh_ind), .cap_valid_o(cap_valid),
        .cap_nib_o(cap_nib), .cap_slot_o(cap_slot), .cap_first_o(cap_first),
        .unaligned_o(unaligned)
    );

    function automatic int slot_len(input int s);
        return ((s % SUBL) == 0 || (s % SUBL) == SUBL / 2) ? 5 : 4;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge: check outputs, drive inputs, advance model.
    task automatic step(input logic r, input logic [3:0] n, input logic rs);
        int exp_stb;
        exp_stb = (mb == slot_len(ms) - 1) ? 1 : 0;
        chk(nib_stb == exp_stb, "R2/R3 strobe", int'(nib_stb), exp_stb);
        chk(cap_valid == pv, "R5/R8 valid", int'(cap_valid), pv);
        if (pv != 0) begin
            chk(cap_nib == pnib && int'(cap_slot) == pslot && cap_first == pfirst,
                "R5 capture", {cap_first, 4'(cap_nib), 8'(cap_slot)},
                {1'(pfirst), 4'(pnib), 8'(pslot)});
        end
        chk(unaligned == mun, "R7 unaligned", int'(unaligned), mun);
        chk(ovh_ind == 1'b0, "R6 ovh_ind", int'(ovh_ind), 0);
        frame_ref = r;
        pay_nib   = n;
        rst       = rs;
        if (rs) begin
            ms = 0; mb = 0; pv = 0; mun = 1; prev_r = 0;
        end else begin
            if (r && prev_r == 0) begin
                pv = 0; ms = 0; mb = 0; mun = 0;
            end else if (exp_stb != 0) begin
                pv = 1; pnib = n; pslot = ms; pfirst = (ms == 0);
                ms = (ms + 1) % SLOTS; mb = 0;
            end else begin
                pv = 0; mb++;
            end
            prev_r = r;
        end
        @(negedge clk);
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) step(1'b0, 4'($urandom), 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int cnt, last_c, longs, c;
        ms = 0; mb = 0; pv = 0; mun = 1; prev_r = 0; pnib = 0; pslot = 0; pfirst = 0;
        @(negedge clk);
        step(1'b0, 4'h0, 1'b1);
        step(1'b0, 4'h0, 1'b0);
        // R1: reset state
        chk(cap_valid == 1'b0 && nib_stb == 1'b0 && unaligned == 1'b1, "R1 reset state",
            {cap_valid, nib_stb, unaligned}, 3'b001);

        // R7: free run before any reference edge, across wrap
        run(2 * FRAME + 7);
        chk(unaligned == 1'b1, "R7 still unaligned", int'(unaligned), 1);

        // R4: first reference, held high for several cycles
        for (int i = 0; i < 6; i++) step(1'b1, 4'($urandom), 1'b0);
        chk(unaligned == 1'b0, "R7 aligned after edge", int'(unaligned), 0);
        run(30);

        // R3: measure frame length and stretched-slot count at the port
        step(1'b1, 4'h5, 1'b0);
        cnt = 0; last_c = 0; longs = 0; c = 0;
        while (cnt < SLOTS && c < 4 * FRAME) begin
            c++;
            if (nib_stb) begin
                if (c - last_c == 5) longs++;
                last_c = c;
                cnt++;
            end
            step(1'b0, 4'($urandom), 1'b0);
        end
        chk(c == FRAME, "R3 frame length", c, FRAME);
        chk(longs == 14, "R3 stretched slots", longs, 14);

        // R4 R8: restart swept across every offset of a frame
        for (int d = 1; d <= FRAME + 2; d++) begin
            step(1'b1, 4'($urandom), 1'b0);
            run(d);
        end

        // R1: reset mid-run restores unaligned state
        run(5);
        step(1'b0, 4'h0, 1'b1);
        step(1'b0, 4'h0, 1'b0);
        chk(unaligned == 1'b1 && cap_valid == 1'b0, "R1 mid-run reset",
            {unaligned, cap_valid}, 2'b10);
        run(FRAME + 3);
        // R8: edge on a strobe cycle right after reset realignment
        step(1'b1, 4'hA, 1'b0);
        run(3 * FRAME);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule